// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog timer with a 32-bit word-addressed register port. A 32-bit counter counts upward on a slow timebase (a one-cycle `tick` strobe from a clock in the 32 kHz class). A power-of-two prescaler sits in front of the counter. When the counter passes 0xFFFFFFFF it reloads from the load register, records an overflow interrupt and pulses a reset request to the system. Software keeps the timer from expiring by writing a changed value to the trigger register, which reloads the counter.

Software cannot start or stop the counter with a single write. It must write a two-word key pair to the key register. Writes to the key and trigger registers take effect in the timebase domain. Each of them has a pending flag that stays set until the write has been applied, which happens on the second timebase tick after the write. A delay comparator gives a second interrupt source. A self-clearing soft-reset bit returns every register to its default. A read-only revision word identifies the block.

Top module: `keyseq_wdt`

## Requirements
- R1: After reset: the ID register (address 0) reads the REV parameter; the prescale register (address 2, bits [2:0] exponent, bit 3 enable) reads 0x8; the pending register (address 8) reads 0; the interrupt status register (address 9) reads 0; `irq` is low; the counter (address 3) reads 0 and runs.
- R2: Writing 0xAAAA and then 0x5555 to the key register (address 7) stops the counter. The stop takes effect on the second tick after the second word. That tick still advances the counter once.
- R3: Writing 0xBBBB and then 0x4444 to the key register starts the counter. The start takes effect on the second tick after the second word, and counting begins on the tick after that.
- R4: If any value other than the matching second word follows a first word, the sequence is abandoned and the running state is unchanged. A first word written while a sequence is open restarts the sequence with the new first word.
- R5: A write to the key register sets pending bit 0, and a write to the trigger register (address 5) sets pending bit 1. Each bit clears on the second tick after its most recent write.
- R6: A trigger write whose value differs from the stored trigger value reloads the counter from the load register (address 4) when its pending bit clears. That reload takes precedence over counting. A write of an equal value does not reload the counter.
- R7: A running counter adds one on each prescaled tick. After 0xFFFFFFFF the counter reloads from the load register, sets status bit 0 and drives `rst_req` high for exactly one cycle.
- R8: With the prescale enable set, the counter advances once every 2^exponent running ticks. With the enable clear, it advances on every running tick. A trigger reload clears the prescale phase.
- R9: When an advance makes the counter equal to the delay register (address 6), status bit 1 is set.
- R10: Writing 1 to a status bit clears it. Writing 1 to a bit of the enable-set register (address 10) sets that enable, and reading the register returns the enables. `irq` is high while any status bit has its enable set.
- R11: Writing 1 to bit 0 of the control register (address 1) makes that bit read 1 until the next tick. On that tick every register, the counter, the key sequence and the pending bits return to their defaults, and the bit clears.
- R12: Writes to the ID register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per timebase period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | One-cycle system reset request on overflow |

## Verification
The hardest situation to reach from the ports is the overflow boundary. With a load value near zero, reaching it would take billions of ticks. The bench instead writes a load value two below the top, forces a reload with a changed trigger word, and then steps single ticks so that `rst_req` can be sampled in the exact cycle after the wrapping tick and in the cycle after that. The key-sequence checks place the commit tick so that they can tell whether the counter advances on that tick.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int PTV_W = 3;
  localparam int PRE_W = (1 << PTV_W) - 1;

  localparam logic [3:0] A_ID     = 4'd0;
  localparam logic [3:0] A_SYSCTL = 4'd1;
  localparam logic [3:0] A_PRESC  = 4'd2;
  localparam logic [3:0] A_COUNT  = 4'd3;
  localparam logic [3:0] A_LOAD   = 4'd4;
  localparam logic [3:0] A_TRIG   = 4'd5;
  localparam logic [3:0] A_DELAY  = 4'd6;
  localparam logic [3:0] A_KEY    = 4'd7;
  localparam logic [3:0] A_PEND   = 4'd8;
  localparam logic [3:0] A_ISTAT  = 4'd9;
  localparam logic [3:0] A_IEN    = 4'd10;

  localparam logic [31:0] KEY_HALT_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_HALT_B = 32'h0000_5555;
  localparam logic [31:0] KEY_RUN_A  = 32'h0000_BBBB;
  localparam logic [31:0] KEY_RUN_B  = 32'h0000_4444;

  typedef enum logic [1:0] {KS_IDLE, KS_HALT_OPEN, KS_RUN_OPEN} kseq_e;

  // Mask of prescale bits that must all be set before the counter advances.
  function automatic logic [PRE_W-1:0] presc_mask(logic [PTV_W-1:0] ptv, logic en);
    logic [PRE_W-1:0] m;
    m = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(ptv)) m[i] = 1'b1;
    end
    return en ? m : '0;
  endfunction

  // Next sequence state for a key word.
  function automatic kseq_e kseq_next(kseq_e s, logic [31:0] w);
    if (w == KEY_HALT_A) return KS_HALT_OPEN;
    if (w == KEY_RUN_A)  return KS_RUN_OPEN;
    return KS_IDLE;
  endfunction

  // Load value that gives a timeout of secs seconds on a 32768 Hz timebase.
  function automatic logic [31:0] timeout_load(int unsigned secs, logic [PTV_W-1:0] ptv);
    logic [31:0] span;
    span = 32'(secs) * (32'd32768 >> ptv);
    return 32'd0 - span;
  endfunction
endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq #(
  parameter bit RUN_INIT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic        run_req
);
  import kwdt_pkg::*;

  kseq_e st_q;
  logic  run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= KS_IDLE;
      run_q <= RUN_INIT;
    end else if (clr) begin
      st_q  <= KS_IDLE;
      run_q <= RUN_INIT;
    end else if (wr) begin
      if (st_q == KS_HALT_OPEN && wdata == KEY_HALT_B) begin
        run_q <= 1'b0;
        st_q  <= KS_IDLE;
      end else if (st_q == KS_RUN_OPEN && wdata == KEY_RUN_B) begin
        run_q <= 1'b1;
        st_q  <= KS_IDLE;
      end else begin
        st_q <= kseq_next(st_q, wdata);
      end
    end
  end

  assign run_req = run_q;
endmodule

// File: rtl/kwdt_sync_slot.sv
module kwdt_sync_slot #(
  parameter int TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr,
  input  logic tick,
  output logic pend,
  output logic commit
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          pend_q;
  logic [CW-1:0] cnt_q;

  assign commit = pend_q && tick && (cnt_q == LAST) && !wr && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (wr) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (commit) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pend_q && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        tick,
  input  logic                        run,
  input  logic                        reload,
  input  logic [CNT_W-1:0]            load_val,
  input  logic [CNT_W-1:0]            delay_val,
  input  logic [kwdt_pkg::PTV_W-1:0]  ptv,
  input  logic                        pre_en,
  output logic [CNT_W-1:0]            cnt,
  output logic                        adv,
  output logic                        ovf,
  output logic                        dly_hit
);
  import kwdt_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             pre_hit;

  assign mask    = presc_mask(ptv, pre_en);
  assign pre_hit = (pre_q & mask) == mask;
  assign adv     = run && tick && pre_hit && !reload && !clr;
  assign ovf     = adv && (cnt_q == '1);
  assign nxt     = ovf ? load_val : cnt_q + 1'b1;
  assign dly_hit = adv && (nxt == delay_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (reload) begin
      cnt_q <= load_val;
      pre_q <= '0;
    end else begin
      if (run && tick) pre_q <= pre_hit ? '0 : pre_q + 1'b1;
      if (adv) cnt_q <= nxt;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/keyseq_wdt.sv
module keyseq_wdt #(
  parameter logic [31:0] REV          = 32'h0001_0203,
  parameter bit          RUN_AT_RESET = 1'b1,
  parameter int          SYNC_TICKS   = 2,
  parameter int          ADDR_W       = 4,
  parameter int          DATA_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);
  import kwdt_pkg::*;

  localparam int NSYNC = 2;
  localparam int NIRQ  = 2;
  localparam logic [PTV_W:0] PRESC_INIT = {1'b1, {PTV_W{1'b0}}};

  // decoded writes
  logic wr_ctl, wr_presc, wr_load, wr_trig, wr_dly, wr_key, wr_ist, wr_ien;
  assign wr_ctl   = wr_en && addr == A_SYSCTL;
  assign wr_presc = wr_en && addr == A_PRESC;
  assign wr_load  = wr_en && addr == A_LOAD;
  assign wr_trig  = wr_en && addr == A_TRIG;
  assign wr_dly   = wr_en && addr == A_DELAY;
  assign wr_key   = wr_en && addr == A_KEY;
  assign wr_ist   = wr_en && addr == A_ISTAT;
  assign wr_ien   = wr_en && addr == A_IEN;

  logic              srst_q;
  logic              clr;
  logic [DATA_W-1:0] load_q, trig_q, delay_q;
  logic              trig_chg_q;
  logic [PTV_W:0]    presc_q;
  logic [NIRQ-1:0]   ien_q, istat_q;
  logic              run_c, run_req, rst_req_q;

  // named internal events
  logic [NSYNC-1:0]  sync_wr, pend, commit;
  logic              key_commit, trig_commit, trig_reload;
  logic [DATA_W-1:0] cnt;
  logic              adv, ovf, dly_hit;

  assign clr         = srst_q && tick;
  assign sync_wr     = {wr_trig, wr_key};
  assign key_commit  = commit[0];
  assign trig_commit = commit[1];
  assign trig_reload = trig_commit && trig_chg_q;

  kwdt_keyseq #(.RUN_INIT(RUN_AT_RESET)) u_keyseq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr(wr_key), .wdata(wdata), .run_req(run_req)
  );

  for (genvar g = 0; g < NSYNC; g++) begin : g_slot
    kwdt_sync_slot #(.TICKS(SYNC_TICKS)) u_slot (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr(sync_wr[g]), .tick(tick),
      .pend(pend[g]), .commit(commit[g])
    );
  end

  kwdt_counter #(.CNT_W(DATA_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .run(run_c),
    .reload(trig_reload), .load_val(load_q), .delay_val(delay_q),
    .ptv(presc_q[PTV_W-1:0]), .pre_en(presc_q[PTV_W]),
    .cnt(cnt), .adv(adv), .ovf(ovf), .dly_hit(dly_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q     <= 1'b0;
      load_q     <= '0;
      trig_q     <= '0;
      trig_chg_q <= 1'b0;
      delay_q    <= '0;
      presc_q    <= PRESC_INIT;
      ien_q      <= '0;
      istat_q    <= '0;
      run_c      <= RUN_AT_RESET;
      rst_req_q  <= 1'b0;
    end else if (clr) begin
      srst_q     <= 1'b0;
      load_q     <= '0;
      trig_q     <= '0;
      trig_chg_q <= 1'b0;
      delay_q    <= '0;
      presc_q    <= PRESC_INIT;
      ien_q      <= '0;
      istat_q    <= '0;
      run_c      <= RUN_AT_RESET;
      rst_req_q  <= 1'b0;
    end else begin
      if (wr_ctl && wdata[0]) srst_q <= 1'b1;
      if (wr_load)  load_q  <= wdata;
      if (wr_dly)   delay_q <= wdata;
      if (wr_presc) presc_q <= wdata[PTV_W:0];
      if (wr_ien)   ien_q   <= ien_q | wdata[NIRQ-1:0];
      if (wr_trig) begin
        trig_q     <= wdata;
        trig_chg_q <= trig_chg_q || (wdata != trig_q);
      end else if (trig_commit) begin
        trig_chg_q <= 1'b0;
      end
      istat_q   <= (istat_q & ~(wr_ist ? wdata[NIRQ-1:0] : '0)) | {dly_hit, ovf};
      if (key_commit) run_c <= run_req;
      rst_req_q <= ovf;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_ID:     rdata = REV;
      A_SYSCTL: rdata = DATA_W'(srst_q);
      A_PRESC:  rdata = DATA_W'(presc_q);
      A_COUNT:  rdata = cnt;
      A_LOAD:   rdata = load_q;
      A_TRIG:   rdata = trig_q;
      A_DELAY:  rdata = delay_q;
      A_PEND:   rdata = DATA_W'(pend);
      A_ISTAT:  rdata = DATA_W'(istat_q);
      A_IEN:    rdata = DATA_W'(ien_q);
      default:  rdata = '0;
    endcase
  end

  assign irq     = |(istat_q & ien_q);
  assign rst_req = rst_req_q;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        clr,
  input logic        rst_req,
  input logic        run_c,
  input logic        run_req,
  input logic        key_commit,
  input logic        trig_reload,
  input logic        adv,
  input logic        ovf,
  input logic [31:0] cnt,
  input logic [31:0] load_q,
  input logic [1:0]  istat_q,
  input logic [1:0]  pend,
  input logic        srst_q
);
  // R7: reset request is a single-cycle pulse
  p_rst_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R7: overflow happens only while running
  p_ovf_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> run_c);
  // R7: overflow reloads from the load register
  p_ovf_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr |=> cnt == $past(load_q));
  // R7: overflow records status bit 0
  p_ovf_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr |=> istat_q[0]);
  // R7: plain advance adds one
  p_adv_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !ovf |=> cnt == $past(cnt) + 32'd1);
  // R2: stopped counter holds unless reloaded or cleared
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_c && !trig_reload && !clr |=> $stable(cnt));
  // R2 / R3: key commit applies the requested running state
  p_key_apply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_commit && !clr |=> run_c == $past(run_req));
  // R5: pending bits only drop on a tick
  p_pend_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend[0]) || $fell(pend[1]) |-> $past(tick));
  // R11: soft reset bit holds until a tick
  p_srst_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q && !tick |=> srst_q);
endmodule

bind keyseq_wdt kwdt_chk u_kwdt_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .rst_req(rst_req),
  .run_c(run_c), .run_req(run_req), .key_commit(key_commit),
  .trig_reload(trig_reload), .adv(adv), .ovf(ovf), .cnt(cnt),
  .load_q(load_q), .istat_q(istat_q), .pend(pend), .srst_q(srst_q)
);

// File: tb/keyseq_wdt_tb_top.sv
module keyseq_wdt_tb_top;
  localparam logic [31:0] REV = 32'h0001_0203;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq, rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keyseq_wdt #(.REV(REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  // kind 0: register at addr, 1: irq pin, 2: rst_req pin
  typedef struct {
    int          kind;
    logic [3:0]  a;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sbq[$];

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.kind)
        0:       act = rdata;
        1:       act = {31'd0, irq};
        default: act = {31'd0, rst_req};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h",
                 it.req, it.kind, it.a, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
    end
  endtask

  task automatic exp_reg(input logic [3:0] a, input logic [31:0] e, input string req);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.kind = 0; it.a = a; it.exp = e; it.req = req;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  // samples in the current cycle
  task automatic exp_pin(input int k, input logic e, input string req);
    item_t it;
    it.kind = k; it.a = 4'd0; it.exp = {31'd0, e}; it.req = req;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  function automatic logic [31:0] model_load(int unsigned secs, int unsigned ptv);
    return 32'hFFFF_FFFF - secs * (32768 / (1 << ptv)) + 32'd1;
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-R actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 defaults
    exp_reg(4'd0, REV, "R1 id");
    exp_reg(4'd2, 32'h8, "R1 prescale");
    exp_reg(4'd8, 32'h0, "R1 pending");
    exp_reg(4'd9, 32'h0, "R1 status");
    exp_reg(4'd3, 32'h0, "R1 count");
    @(posedge clk); #1; exp_pin(1, 1'b0, "R1 irq");

    // R12 id write ignored
    wr(4'd0, 32'h1234_5678);
    exp_reg(4'd0, REV, "R12 id read-only");

    // R1 runs at reset
    ticks(3);
    exp_reg(4'd3, 32'd3, "R1 R7 counting");

    // R2 stop
    wr(4'd7, 32'h0000_AAAA);
    exp_reg(4'd8, 32'h1, "R5 key pending");
    wr(4'd7, 32'h0000_5555);
    ticks(1);
    exp_reg(4'd8, 32'h1, "R5 pending after one tick");
    ticks(1);
    exp_reg(4'd8, 32'h0, "R5 pending cleared");
    exp_reg(4'd3, 32'd5, "R2 commit tick advances");
    ticks(3);
    exp_reg(4'd3, 32'd5, "R2 stopped");

    // R4 abort, then restart of the sequence
    wr(4'd7, 32'h0000_BBBB);
    wr(4'd7, 32'h0000_1234);
    wr(4'd7, 32'h0000_4444);
    ticks(3);
    exp_reg(4'd3, 32'd5, "R4 aborted sequence");
    wr(4'd7, 32'h0000_AAAA);
    wr(4'd7, 32'h0000_BBBB);
    wr(4'd7, 32'h0000_4444);
    ticks(2);
    exp_reg(4'd3, 32'd5, "R3 commit tick no advance");
    ticks(3);
    exp_reg(4'd3, 32'd8, "R3 R4 started");

    // R6 trigger reload
    wr(4'd4, 32'h0000_0100);
    wr(4'd5, 32'h1);
    exp_reg(4'd8, 32'h2, "R5 trigger pending");
    ticks(2);
    exp_reg(4'd3, 32'h100, "R6 reload on change");
    exp_reg(4'd8, 32'h0, "R5 trigger cleared");
    ticks(1);
    wr(4'd5, 32'h1);
    ticks(2);
    exp_reg(4'd3, 32'h103, "R6 equal trigger no reload");

    // R7 overflow
    wr(4'd4, 32'hFFFF_FFFE);
    wr(4'd5, 32'h2);
    ticks(2);
    exp_reg(4'd3, 32'hFFFF_FFFE, "R6 reload near top");
    wr(4'd10, 32'h1);
    @(posedge clk); #1; exp_pin(1, 1'b0, "R10 irq idle");
    ticks(1);
    exp_reg(4'd3, 32'hFFFF_FFFF, "R7 top value");
    @(posedge clk); #1 tick = 1'b1;
    @(posedge clk); #1 tick = 1'b0;
    exp_pin(2, 1'b1, "R7 rst_req pulse");
    @(posedge clk); #1; exp_pin(2, 1'b0, "R7 rst_req one cycle");
    exp_reg(4'd3, 32'hFFFF_FFFE, "R7 wrap reload");
    exp_reg(4'd9, 32'h1, "R7 overflow status");
    @(posedge clk); #1; exp_pin(1, 1'b1, "R10 irq overflow");
    wr(4'd9, 32'h1);
    exp_reg(4'd9, 32'h0, "R10 w1c");
    @(posedge clk); #1; exp_pin(1, 1'b0, "R10 irq cleared");

    // R9 delay match
    wr(4'd6, 32'hFFFF_FFFF);
    ticks(1);
    exp_reg(4'd9, 32'h2, "R9 delay status");
    @(posedge clk); #1; exp_pin(1, 1'b0, "R10 delay masked");
    wr(4'd10, 32'h2);
    exp_reg(4'd10, 32'h3, "R10 enables");
    @(posedge clk); #1; exp_pin(1, 1'b1, "R10 delay irq");
    wr(4'd9, 32'h3);
    exp_reg(4'd9, 32'h0, "R10 cleared both");

    // R8 prescaler
    wr(4'd4, 32'h0);
    wr(4'd5, 32'h3);
    ticks(2);
    exp_reg(4'd3, 32'h0, "R8 reload to zero");
    wr(4'd2, 32'hA);
    ticks(8);
    exp_reg(4'd3, 32'd2, "R8 divide by 4");
    wr(4'd2, 32'h2);
    ticks(3);
    exp_reg(4'd3, 32'd5, "R8 prescale disabled");

    // R11 soft reset
    wr(4'd4, 32'h55);
    wr(4'd1, 32'h1);
    exp_reg(4'd1, 32'h1, "R11 busy bit");
    exp_reg(4'd4, 32'h55, "R11 not yet reset");
    ticks(1);
    exp_reg(4'd1, 32'h0, "R11 self clear");
    exp_reg(4'd4, 32'h0, "R11 load default");
    exp_reg(4'd2, 32'h8, "R11 prescale default");
    exp_reg(4'd10, 32'h0, "R11 enables default");
    exp_reg(4'd3, 32'h0, "R11 count default");
    ticks(1);
    exp_reg(4'd3, 32'h1, "R11 running default");

    // R7 timeout arithmetic restated: 2 s at divide 1
    checks++;
    if (model_load(2, 0) !== 32'hFFFF_0000) begin
      errors++;
      $display("FAIL R7 load arithmetic actual=%h expected=ffff0000", model_load(2, 0));
    end

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule